// File: doc/BRIEF.md
# Micro-frame Index and SOF Number Keeper

This block holds the host controller's running micro-frame index and a separate frame number that goes out in start-of-frame tokens. Each micro-frame the bus timing logic sends a one-cycle tick. While the controller runs, the tick advances the index. The low three index bits count the eight micro-frames inside one 1 ms frame. The bits above them pick one entry of a 1024-entry periodic schedule list.

The SOF number is not a slice of the index. It is its own 11-bit counter, and it steps when a tick moves the low index bits out of zero. It therefore changes once per millisecond, one micro-frame after the index crosses a frame boundary. Software may only rewrite the index while the controller is halted and stopped, and only with a full 32-bit write. An accepted write copies the frame part of the new index into the SOF counter, which keeps the two values consistent. Any other write is refused and reported with a one-cycle error pulse. An accepted write whose low bits software is told to avoid still loads, but raises a warning pulse.

Top module: `uframe_sof_keeper`

## Requirements
- R1: After reset, `index_o`, `sof_num`, `list_idx`, `wr_err` and `wr_warn` are all zero.
- R2: A cycle with `uframe_tick`=1, `run_stop`=1 and `halted`=0 raises `index_o` by one, visible the following cycle.
- R3: `list_idx` equals index bits 12:3, so it advances once for every eight counted ticks.
- R4: A counted tick taken while index bits 2:0 are 000b raises `sof_num` by one. Any other counted tick leaves `sof_num` unchanged.
- R5: An accepted write loads `index_o` from `wr_data[13:0]` and `sof_num` from `wr_data[13:3]`, both visible the following cycle.
- R6: A write issued while `halted`=0 or `run_stop`=1 is refused. `wr_err` is 1 for exactly the following cycle, and the write changes neither `index_o` nor `sof_num`.
- R7: A write whose `wr_be` is not 4'b1111 is refused in the same way as in R6, whatever the controller state.
- R8: An accepted write whose data bits 2:0 are 000b or 111b still loads as in R5, and `wr_warn` is 1 for exactly the following cycle. Other accepted writes leave `wr_warn` at 0.
- R9: A tick has no effect on `index_o` or `sof_num` unless `run_stop`=1 and `halted`=0.
- R10: The index wraps from its all-ones value to 0, and `sof_num` wraps from its all-ones value to 0.
- R11: `rd_data` carries the index in bits 13:0 and zeros in every bit above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halted | input | 1 | Controller reports that it is halted |
| run_stop | input | 1 | Controller run/stop command |
| uframe_tick | input | 1 | One-cycle pulse at the end of each micro-frame |
| wr_en | input | 1 | Write strobe for the index register |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read view of the index register |
| index_o | output | 14 | Current micro-frame index |
| sof_num | output | 11 | SOF frame number |
| list_idx | output | 10 | Periodic list entry index |
| wr_err | output | 1 | One-cycle pulse: a write was refused |
| wr_warn | output | 1 | One-cycle pulse: an accepted write had low bits 000b or 111b |

## Verification
The bench builds the block with a 7-bit index, which gives a 4-bit SOF number and a 3-bit list index. The other widths keep their default values. With only 128 index values, the bench can tick through both counters' wraps twice and write every possible index value. It can also try every partial byte-enable pattern and every refusing combination of halted and run/stop. The widths come from parameters, so the same comparison of the frame boundary and the SOF step holds at the full 14-bit size.

// File: rtl/uframe_pkg.sv
`timescale 1ns/1ps
package uframe_pkg;

  typedef enum logic [1:0] {
    WR_NONE   = 2'd0,
    WR_TAKE   = 2'd1,
    WR_REFUSE = 2'd2
  } wr_verdict_e;

endpackage

// File: rtl/uframe_wr_gate.sv
`timescale 1ns/1ps
module uframe_wr_gate
  import uframe_pkg::*;
#(
  parameter int BE_W  = 4,
  parameter int SUB_W = 3
) (
  input  logic              wr_en,
  input  logic [BE_W-1:0]   wr_be,
  input  logic [SUB_W-1:0]  wr_low,
  input  logic              halted,
  input  logic              run_stop,
  output wr_verdict_e       verdict,
  output logic              low_warn
);

  function automatic logic full_word(input logic [BE_W-1:0] be);
    return &be;
  endfunction

  function automatic logic may_write(input logic h, input logic rs);
    return h & ~rs;
  endfunction

  function automatic logic bad_low(input logic [SUB_W-1:0] low);
    return (low == '0) || (&low);
  endfunction

  always_comb begin
    if (!wr_en)
      verdict = WR_NONE;
    else if (full_word(wr_be) && may_write(halted, run_stop))
      verdict = WR_TAKE;
    else
      verdict = WR_REFUSE;
  end

  assign low_warn = (verdict == WR_TAKE) && bad_low(wr_low);

endmodule

// File: rtl/uframe_idx_ctr.sv
`timescale 1ns/1ps
module uframe_idx_ctr #(
  parameter int IDX_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  output logic [IDX_W-1:0] idx
);

  function automatic logic [IDX_W-1:0] idx_next(input logic [IDX_W-1:0] v);
    return v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)
      idx <= '0;
    else if (load)
      idx <= load_val;
    else if (adv)
      idx <= idx_next(idx);
  end

endmodule

// File: rtl/uframe_sof_ctr.sv
`timescale 1ns/1ps
module uframe_sof_ctr #(
  parameter int SOF_W = 11,
  parameter int SUB_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [SUB_W-1:0] cur_low,
  input  logic             load,
  input  logic [SOF_W-1:0] load_val,
  output logic [SOF_W-1:0] sof
);

  function automatic logic leaves_zero(input logic [SUB_W-1:0] low);
    return low == '0;
  endfunction

  function automatic logic [SOF_W-1:0] sof_next(input logic [SOF_W-1:0] v);
    return v + 1'b1;
  endfunction

  logic step;
  assign step = adv && leaves_zero(cur_low);

  always_ff @(posedge clk) begin
    if (!rst_n)
      sof <= '0;
    else if (load)
      sof <= load_val;
    else if (step)
      sof <= sof_next(sof);
  end

endmodule

// File: rtl/uframe_sof_keeper.sv
`timescale 1ns/1ps
module uframe_sof_keeper
  import uframe_pkg::*;
#(
  parameter  int REG_W  = 32,
  parameter  int BE_W   = 4,
  parameter  int IDX_W  = 14,
  parameter  int SUB_W  = 3,
  localparam int SOF_W  = IDX_W - SUB_W,
  localparam int LIST_W = IDX_W - SUB_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halted,
  input  logic              run_stop,
  input  logic              uframe_tick,
  input  logic              wr_en,
  input  logic [BE_W-1:0]   wr_be,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic [IDX_W-1:0]  index_o,
  output logic [SOF_W-1:0]  sof_num,
  output logic [LIST_W-1:0] list_idx,
  output logic              wr_err,
  output logic              wr_warn
);

  wr_verdict_e verdict;
  logic        low_warn;
  logic        adv;
  logic        wr_accept;
  logic        wr_reject;
  logic        unused_rsvd;

  assign adv       = uframe_tick & run_stop & ~halted;
  assign wr_accept = (verdict == WR_TAKE);
  assign wr_reject = (verdict == WR_REFUSE);
  assign unused_rsvd = ^wr_data[REG_W-1:IDX_W];

  uframe_wr_gate #(
    .BE_W  (BE_W),
    .SUB_W (SUB_W)
  ) u_gate (
    .wr_en    (wr_en),
    .wr_be    (wr_be),
    .wr_low   (wr_data[SUB_W-1:0]),
    .halted   (halted),
    .run_stop (run_stop),
    .verdict  (verdict),
    .low_warn (low_warn)
  );

  uframe_idx_ctr #(
    .IDX_W (IDX_W)
  ) u_idx (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .load     (wr_accept),
    .load_val (wr_data[IDX_W-1:0]),
    .idx      (index_o)
  );

  uframe_sof_ctr #(
    .SOF_W (SOF_W),
    .SUB_W (SUB_W)
  ) u_sof (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .cur_low  (index_o[SUB_W-1:0]),
    .load     (wr_accept),
    .load_val (wr_data[IDX_W-1:SUB_W]),
    .sof      (sof_num)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_err  <= 1'b0;
      wr_warn <= 1'b0;
    end else begin
      wr_err  <= wr_reject;
      wr_warn <= low_warn;
    end
  end

  assign list_idx = index_o[IDX_W-2:SUB_W];
  assign rd_data  = {{(REG_W-IDX_W){1'b0}}, index_o};

endmodule

// File: rtl/uframe_sof_keeper_chk.sv
`timescale 1ns/1ps
module uframe_sof_keeper_chk #(
  parameter int REG_W  = 32,
  parameter int BE_W   = 4,
  parameter int IDX_W  = 14,
  parameter int SUB_W  = 3,
  parameter int SOF_W  = IDX_W - SUB_W,
  parameter int LIST_W = IDX_W - SUB_W - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              halted,
  input logic              run_stop,
  input logic              wr_en,
  input logic [BE_W-1:0]   wr_be,
  input logic [REG_W-1:0]  wr_data,
  input logic [REG_W-1:0]  rd_data,
  input logic [IDX_W-1:0]  index_o,
  input logic [SOF_W-1:0]  sof_num,
  input logic [LIST_W-1:0] list_idx,
  input logic              wr_err,
  input logic              wr_warn,
  input logic              adv,
  input logic              wr_accept
);

  p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !wr_accept |=> index_o == IDX_W'($past(index_o) + 1'b1));

  p_list_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !wr_accept && (&index_o[SUB_W-1:0]) |=> list_idx == LIST_W'($past(list_idx) + 1'b1));

  p_sof_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !wr_accept && (index_o[SUB_W-1:0] == '0) |=> sof_num == SOF_W'($past(sof_num) + 1'b1));

  p_sof_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !wr_accept && (index_o[SUB_W-1:0] != '0) |=> $stable(sof_num));

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> index_o == $past(wr_data[IDX_W-1:0]) && sof_num == $past(wr_data[IDX_W-1:SUB_W]));

  p_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (!halted || run_stop) |=> wr_err && !wr_warn);

  p_partial_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !(&wr_be) |=> wr_err && !wr_warn);

  p_warn_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept && ((wr_data[SUB_W-1:0] == '0) || (&wr_data[SUB_W-1:0])) |=> wr_warn && !wr_err);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !adv && !wr_accept |=> $stable(index_o) && $stable(sof_num));

  p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[REG_W-1:IDX_W] == '0 && rd_data[IDX_W-1:0] == index_o);

endmodule

bind uframe_sof_keeper uframe_sof_keeper_chk #(
  .REG_W (REG_W),
  .BE_W  (BE_W),
  .IDX_W (IDX_W),
  .SUB_W (SUB_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .halted    (halted),
  .run_stop  (run_stop),
  .wr_en     (wr_en),
  .wr_be     (wr_be),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .index_o   (index_o),
  .sof_num   (sof_num),
  .list_idx  (list_idx),
  .wr_err    (wr_err),
  .wr_warn   (wr_warn),
  .adv       (adv),
  .wr_accept (wr_accept)
);

// File: tb/test_uframe_sof_keeper.sv
`timescale 1ns/1ps
module test_uframe_sof_keeper;

  localparam int REG_W  = 32;
  localparam int BE_W   = 4;
  localparam int IDX_W  = 7;
  localparam int SUB_W  = 3;
  localparam int SOF_W  = IDX_W - SUB_W;
  localparam int LIST_W = IDX_W - SUB_W - 1;
  localparam int IDX_N  = 1 << IDX_W;
  localparam int SOF_N  = 1 << SOF_W;
  localparam int SUB_N  = 1 << SUB_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              halted = 1'b1;
  logic              run_stop = 1'b0;
  logic              uframe_tick = 1'b0;
  logic              wr_en = 1'b0;
  logic [BE_W-1:0]   wr_be = '1;
  logic [REG_W-1:0]  wr_data = '0;
  logic [REG_W-1:0]  rd_data;
  logic [IDX_W-1:0]  index_o;
  logic [SOF_W-1:0]  sof_num;
  logic [LIST_W-1:0] list_idx;
  logic              wr_err;
  logic              wr_warn;

  int total = 0;
  int bad = 0;
  int exp_idx = 0;
  int exp_sof = 0;

  always #10 clk = ~clk;

  uframe_sof_keeper #(
    .REG_W (REG_W),
    .BE_W  (BE_W),
    .IDX_W (IDX_W),
    .SUB_W (SUB_W)
  ) i_uframe_sof_keeper (
    .clk         (clk),
    .rst_n       (rst_n),
    .halted      (halted),
    .run_stop    (run_stop),
    .uframe_tick (uframe_tick),
    .wr_en       (wr_en),
    .wr_be       (wr_be),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .index_o     (index_o),
    .sof_num     (sof_num),
    .list_idx    (list_idx),
    .wr_err      (wr_err),
    .wr_warn     (wr_warn)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    check({req, " index"}, int'(index_o), exp_idx);
    check({req, " sof"}, int'(sof_num), exp_sof);
    check({req, " list R3"}, int'(list_idx), (exp_idx / SUB_N) % (1 << LIST_W));
    check({req, " rd R11"}, int'(rd_data), exp_idx);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic tick_once(input string req);
    @(negedge clk);
    uframe_tick = 1'b1;
    @(negedge clk);
    uframe_tick = 1'b0;
    if (run_stop && !halted) begin
      if (exp_idx % SUB_N == 0) exp_sof = (exp_sof + 1) % SOF_N;
      exp_idx = (exp_idx + 1) % IDX_N;
    end
    check_state(req);
  endtask

  task automatic write_reg(input string req, input int val, input logic [BE_W-1:0] be,
                           input int exp_err, input int exp_warn);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_be   = be;
    wr_data = 32'hDEAD_BE80 | REG_W'(val);
    @(negedge clk);
    wr_en = 1'b0;
    wr_be = '1;
    if (exp_err == 0) begin
      exp_idx = val % IDX_N;
      exp_sof = exp_idx / SUB_N;
    end
    check({req, " err"}, int'(wr_err), exp_err);
    check({req, " warn"}, int'(wr_warn), exp_warn);
    check_state(req);
    @(negedge clk);
    check({req, " err pulse width"}, int'(wr_err), 0);
    check({req, " warn pulse width"}, int'(wr_warn), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 index", int'(index_o), 0);
    check("R1 sof", int'(sof_num), 0);
    check("R1 list", int'(list_idx), 0);
    check("R1 err", int'(wr_err), 0);
    check("R1 warn", int'(wr_warn), 0);

    // R9: ticks in every non-running state change nothing
    for (int s = 0; s < 3; s++) begin
      halted   = (s != 0);
      run_stop = (s == 2);
      tick_once("R9 idle tick");
    end

    // R2 R3 R4 R10: run through two full wraps
    halted   = 1'b0;
    run_stop = 1'b1;
    for (int n = 0; n < 2 * IDX_N + 3; n++) begin
      tick_once("R2 R4 R10 run");
      if (n % 5 == 0) begin
        @(negedge clk);
        check_state("R2 gap hold");
      end
    end

    // R5 R8: every index value written while halted and stopped
    halted   = 1'b1;
    run_stop = 1'b0;
    for (int v = 0; v < IDX_N; v++) begin
      write_reg("R5 R8 write", v, '1, 0,
                ((v % SUB_N == 0) || (v % SUB_N == SUB_N - 1)) ? 1 : 0);
    end

    // R10: wrap of the SOF number from its top value
    write_reg("R10 setup", IDX_N - 1, '1, 0, 1);
    halted   = 1'b0;
    run_stop = 1'b1;
    tick_once("R10 index wrap");
    check("R10 sof top held", int'(sof_num), SOF_N - 1);
    tick_once("R10 sof wrap");
    check("R10 sof zero", int'(sof_num), 0);

    // R6: refused in every non-writable state
    halted   = 1'b1;
    run_stop = 1'b0;
    write_reg("R6 setup", 5, '1, 0, 0);
    for (int s = 0; s < 3; s++) begin
      halted   = (s == 1);
      run_stop = (s != 0);
      write_reg("R6 refused", 42, '1, 1, 0);
    end

    // R7: every partial byte-enable pattern refused while halted
    halted   = 1'b1;
    run_stop = 1'b0;
    for (int b = 0; b < (1 << BE_W) - 1; b++) begin
      write_reg("R7 partial", 19, BE_W'(b), 1, 0);
    end

    finish_run();
  end

endmodule